// File: doc/BRIEF.md
# Shared Receive Silo for a Sixteen-Line Serial Multiplexer

This block collects received characters from sixteen asynchronous serial lines into one first-in, first-out store. At most one line presents a finished character per cycle, together with its line number and its parity and framing error indications. The silo turns each character into a 15-bit entry that holds the character, the line it came from and the error flags. A host reads the receive character register to see the oldest entry, and the same read removes that entry. When the silo is empty the register reads as zero, so software keeps reading while the top bit is set, which makes the value negative.

A receive interrupt flag is raised by hardware in two cases: a character lands in an empty silo, or a store pushes the fill level up to an alarm threshold that software programs. The interrupt request is the flag qualified by an enable bit. A maintenance bit lets software force the flag so that the interrupt path can be probed. A master clear bit in the control register empties the silo and clears all control state.

Top module: `mux_rx_silo`

## Requirements
- R1: The head word reads bit 15 = 1 (valid), bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number, bits 7:0 = character. Entries leave in the order they were stored.
- R2: When the silo is empty the head word reads 16'h0000, and a pop request has no effect.
- R3: The silo holds 64 entries. A character that arrives while the silo is full and no pop is requested is dropped, and the stored contents and fill level stay unchanged.
- R4: After one or more characters are dropped, the next entry stored has bit 14 set. Later entries have bit 14 clear until another drop occurs.
- R5: A push and a pop in the same cycle both take effect, and the fill level stays the same. This also holds when the silo is full.
- R6: Storing a character into an empty silo sets the interrupt flag (control bit 7).
- R7: A 7-bit alarm level is written through its own write port and resets to 0. A store without a pop that brings the fill level equal to a non-zero alarm level sets the flag.
- R8: A control write loads the enable from bit 6. When bit 9 is 0, writing bit 7 = 0 clears the flag and writing bit 7 = 1 leaves it unchanged. If hardware sets the flag in the same cycle, the flag ends up set.
- R9: A control write with bit 9 = 1 loads the flag from bit 7, which forces an interrupt. Bit 9 reads back the maintenance bit.
- R10: The interrupt request is high exactly when the flag and the enable are both set.
- R11: A control write with bit 11 = 1 empties the silo by the next cycle and clears the flag, enable, maintenance bit, pending overrun and alarm level. It wins over a push in the same cycle, and bit 11 reads back 0.
- R12: After reset the silo is empty, the control register reads 16'h0000, the alarm level is 0 and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chValid | input | 1 | A finished character is presented this cycle |
| chLine | input | 4 | Line number of the presented character |
| chData | input | 8 | Character bits |
| chParErr | input | 1 | Parity error on this character |
| chFrmErr | input | 1 | Framing error (break) on this character |
| popEn | input | 1 | Read of the receive character register; removes the head entry |
| rxWord | output | 16 | Head entry with the valid bit, or zero when the silo is empty |
| csrWrEn | input | 1 | Control register write strobe |
| csrWrData | input | 16 | Control register write data |
| csrRdData | output | 16 | Control register read value |
| alarmWrEn | input | 1 | Alarm level write strobe |
| alarmWrData | input | 7 | Alarm level write data |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
Two kinds of events can land in the same cycle. A push can coincide with a pop, including when the silo is full, and a hardware flag set can coincide with a software write that clears the flag. The bench causes the first collision by filling the silo to 64 entries and then driving a character and a read together. It judges the result by the fill level and by the order of the entries it drains afterwards. It causes the second collision by writing the control register with bit 7 clear in the same cycle that a character enters an empty silo, then checks that the flag is still set. Master clear is also driven in the same cycle as a push, to confirm that the clear wins.

// File: rtl/mux_rx_silo_pkg.sv
package mux_rx_silo_pkg;
  localparam int ENA_BIT   = 6;
  localparam int FLAG_BIT  = 7;
  localparam int MAINT_BIT = 9;
  localparam int MCLR_BIT  = 11;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic ovrTag;
  } siloStrobes_t;
endpackage

// File: rtl/silo_datapath.sv
module silo_datapath
  import mux_rx_silo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 4,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int EW = 3 + LINE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  siloStrobes_t      strb,
  input  logic [LINE_W-1:0] chLine,
  input  logic [DATA_W-1:0] chData,
  input  logic              chParErr,
  input  logic              chFrmErr,
  output logic [EW:0]       rxWord,
  output logic [CW-1:0]     fill
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] headPtr, tailPtr;
  logic [EW-1:0] newEntry;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign newEntry = {strb.ovrTag, chFrmErr, chParErr, chLine, chData};

  always_ff @(posedge clk) begin
    if (strb.push) mem[tailPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      fill    <= '0;
    end else if (strb.clear) begin
      headPtr <= '0;
      tailPtr <= '0;
      fill    <= '0;
    end else begin
      if (strb.push) tailPtr <= advance(tailPtr);
      if (strb.pop)  headPtr <= advance(headPtr);
      case ({strb.push, strb.pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign rxWord = (fill != '0) ? {1'b1, mem[headPtr]} : '0;
endmodule

// File: rtl/silo_control.sv
module silo_control
  import mux_rx_silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chValid,
  input  logic          popEn,
  input  logic          csrWrEn,
  input  logic [15:0]   csrWrData,
  input  logic          alarmWrEn,
  input  logic [CW-1:0] alarmWrData,
  input  logic [CW-1:0] fill,
  output siloStrobes_t  strb,
  output logic [15:0]   csrRdData,
  output logic          rxIrq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          rxFlag, rxEna, maintMode, pendOvr;
  logic [CW-1:0] alarmLevel;
  logic          masterClr, isEmpty, isFull, popOk, pushOk, dropChar, setFlag;
  logic [CW:0]   fillPlusOne;
  logic          flagAfterWrite;
  logic          unusedBits;

  assign masterClr   = csrWrEn && csrWrData[MCLR_BIT];
  assign isEmpty     = (fill == '0);
  assign isFull      = (fill == FULL);
  assign popOk       = popEn && !isEmpty && !masterClr;
  assign pushOk      = chValid && !masterClr && (!isFull || popOk);
  assign dropChar    = chValid && !masterClr && !pushOk;
  assign fillPlusOne = {1'b0, fill} + (CW+1)'(1);
  assign setFlag     = pushOk && !popOk &&
                       (isEmpty || ((alarmLevel != '0) && (fillPlusOne == {1'b0, alarmLevel})));

  always_comb begin
    flagAfterWrite = rxFlag;
    if (csrWrEn) begin
      if (csrWrData[MAINT_BIT])      flagAfterWrite = csrWrData[FLAG_BIT];
      else if (!csrWrData[FLAG_BIT]) flagAfterWrite = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxFlag     <= 1'b0;
      rxEna      <= 1'b0;
      maintMode  <= 1'b0;
      pendOvr    <= 1'b0;
      alarmLevel <= '0;
    end else if (masterClr) begin
      rxFlag     <= 1'b0;
      rxEna      <= 1'b0;
      maintMode  <= 1'b0;
      pendOvr    <= 1'b0;
      alarmLevel <= '0;
    end else begin
      rxFlag <= setFlag ? 1'b1 : flagAfterWrite;
      if (csrWrEn) begin
        rxEna     <= csrWrData[ENA_BIT];
        maintMode <= csrWrData[MAINT_BIT];
      end
      if (pushOk)        pendOvr <= 1'b0;
      else if (dropChar) pendOvr <= 1'b1;
      if (alarmWrEn) alarmLevel <= alarmWrData;
    end
  end

  always_comb begin
    strb.push   = pushOk;
    strb.pop    = popOk;
    strb.clear  = masterClr;
    strb.ovrTag = pendOvr;
  end

  always_comb begin
    csrRdData            = '0;
    csrRdData[ENA_BIT]   = rxEna;
    csrRdData[FLAG_BIT]  = rxFlag;
    csrRdData[MAINT_BIT] = maintMode;
  end

  assign rxIrq      = rxFlag && rxEna;
  assign unusedBits = ^{csrWrData[15:12], csrWrData[10], csrWrData[8], csrWrData[5:0]};
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import mux_rx_silo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 4,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int WW = 4 + LINE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chValid,
  input  logic [LINE_W-1:0] chLine,
  input  logic [DATA_W-1:0] chData,
  input  logic              chParErr,
  input  logic              chFrmErr,
  input  logic              popEn,
  output logic [WW-1:0]     rxWord,
  input  logic              csrWrEn,
  input  logic [15:0]       csrWrData,
  output logic [15:0]       csrRdData,
  input  logic              alarmWrEn,
  input  logic [CW-1:0]     alarmWrData,
  output logic              rxIrq
);
  siloStrobes_t  strb;
  logic [CW-1:0] fill;

  silo_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .popEn(popEn),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .alarmWrEn(alarmWrEn), .alarmWrData(alarmWrData),
    .fill(fill), .strb(strb), .csrRdData(csrRdData), .rxIrq(rxIrq)
  );

  silo_datapath #(.DEPTH(DEPTH), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .chLine(chLine), .chData(chData),
    .chParErr(chParErr), .chFrmErr(chFrmErr), .rxWord(rxWord), .fill(fill)
  );
endmodule

// File: rtl/mux_rx_silo_checker.sv
module mux_rx_silo_checker #(
  parameter int DEPTH = 64,
  parameter int WW    = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chValid,
  input logic          popEn,
  input logic          csrWrEn,
  input logic [15:0]   csrWrData,
  input logic [WW-1:0] rxWord,
  input logic [15:0]   csrRdData,
  input logic          rxIrq,
  input logic [CW-1:0] fill
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  logic mclr;
  assign mclr = csrWrEn && csrWrData[11];

  p_mclr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (rxWord == '0) && (csrRdData == 16'h0000));

  p_empty_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rxWord[WW-1] |-> (rxWord == '0));

  p_first_char_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxWord[WW-1] && chValid && !mclr) |=> (rxWord[WW-1] && csrRdData[7]));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill == FULL) && chValid && !popEn && !mclr) |=> ((fill == FULL) && $stable(rxWord)));

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  p_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxWord[WW-1] && popEn && chValid && !mclr) |=> $stable(fill));

  p_irq_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> (csrRdData[7] && csrRdData[6]));
endmodule

bind mux_rx_silo mux_rx_silo_checker #(.DEPTH(DEPTH), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chValid(chValid), .popEn(popEn),
  .csrWrEn(csrWrEn), .csrWrData(csrWrData), .rxWord(rxWord),
  .csrRdData(csrRdData), .rxIrq(rxIrq), .fill(fill)
);

// File: tb/mux_rx_silo_bench.sv
module mux_rx_silo_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chValid = 1'b0;
  logic [3:0]  chLine = '0;
  logic [7:0]  chData = '0;
  logic        chParErr = 1'b0, chFrmErr = 1'b0, popEn = 1'b0;
  logic [15:0] rxWord;
  logic        csrWrEn = 1'b0;
  logic [15:0] csrWrData = '0;
  logic [15:0] csrRdData;
  logic        alarmWrEn = 1'b0;
  logic [6:0]  alarmWrData = '0;
  logic        rxIrq;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R12 reset";

  logic [15:0] mq[$];
  logic mFlag = 0, mEna = 0, mMaint = 0, mPend = 0;
  logic [6:0] mAlarm = '0;

  always #10 clk = ~clk;

  mux_rx_silo u_mux_rx_silo (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .chLine(chLine), .chData(chData),
    .chParErr(chParErr), .chFrmErr(chFrmErr), .popEn(popEn), .rxWord(rxWord),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .alarmWrEn(alarmWrEn), .alarmWrData(alarmWrData), .rxIrq(rxIrq)
  );

  task automatic check(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [15:0] expWord, expCsr;
    expWord = (mq.size() > 0) ? mq[0] : 16'h0000;
    expCsr = '0;
    expCsr[6] = mEna; expCsr[7] = mFlag; expCsr[9] = mMaint;
    check(rxWord === expWord, "R1 head word", rxWord, expWord);
    check(csrRdData === expCsr, "R8 control read", csrRdData, expCsr);
    check(rxIrq === (mFlag && mEna), "R10 irq", {15'b0, rxIrq}, {15'b0, mFlag && mEna});
  endtask

  task automatic step(input logic v, input logic [3:0] ln, input logic [7:0] d,
                      input logic p, input logic f, input logic pop,
                      input logic wr, input logic [15:0] wd,
                      input logic awr, input logic [6:0] ad);
    int cnt;
    bit popOk, acc, setF;
    logic flagN;
    chValid = v; chLine = ln; chData = d; chParErr = p; chFrmErr = f; popEn = pop;
    csrWrEn = wr; csrWrData = wd; alarmWrEn = awr; alarmWrData = ad;
    if (wr && wd[11]) begin
      mq.delete(); mFlag = 0; mEna = 0; mMaint = 0; mPend = 0; mAlarm = '0;
    end else begin
      cnt = mq.size();
      popOk = pop && (cnt > 0);
      acc = v && ((cnt < DEPTH) || popOk);
      setF = acc && !popOk && ((cnt == 0) || ((mAlarm != 0) && (cnt + 1 == int'(mAlarm))));
      if (popOk) void'(mq.pop_front());
      if (acc) begin
        mq.push_back({1'b1, mPend, f, p, ln, d});
        mPend = 0;
      end else if (v) mPend = 1;
      flagN = mFlag;
      if (wr) begin
        mEna = wd[6]; mMaint = wd[9];
        if (wd[9]) flagN = wd[7];
        else if (!wd[7]) flagN = 0;
      end
      mFlag = setF ? 1'b1 : flagN;
      if (awr) mAlarm = ad;
    end
    @(negedge clk);
    chValid = 0; popEn = 0; csrWrEn = 0; alarmWrEn = 0;
    compareAll();
  endtask

  task automatic push(input logic [3:0] ln, input logic [7:0] d, input logic p, input logic f);
    step(1, ln, d, p, f, 0, 0, '0, 0, '0);
  endtask
  task automatic pop();
    step(0, '0, '0, 0, 0, 1, 0, '0, 0, '0);
  endtask
  task automatic wcsr(input logic [15:0] wd);
    step(0, '0, '0, 0, 0, 0, 1, wd, 0, '0);
  endtask
  task automatic walarm(input logic [6:0] a);
    step(0, '0, '0, 0, 0, 0, 0, '0, 1, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R12 reset";
    compareAll();

    phase = "R1 R3 fill sweep";
    for (int l = 0; l < 16; l++)
      for (int e = 0; e < 4; e++)
        push(4'(l), 8'(l * 16 + e * 5 + 3), e[0], e[1]);
    check(rxWord === 16'h8003, "R3 full head", rxWord, 16'h8003);

    phase = "R3 drop when full";
    push(4'd7, 8'hA5, 0, 0);
    check(rxWord === 16'h8003, "R3 head unchanged after drop", rxWord, 16'h8003);

    phase = "R5 R4 push pop at full";
    step(1, 4'd9, 8'h5C, 1, 0, 1, 0, '0, 0, '0);
    check(mq[DEPTH-1] === 16'hD95C, "R4 overrun tag on stored entry", mq[DEPTH-1], 16'hD95C);
    pop();
    push(4'd2, 8'h11, 0, 0);

    phase = "R1 drain order";
    while (mq.size() > 0) pop();

    phase = "R2 empty pop";
    pop();
    check(rxWord === 16'h0000, "R2 empty word", rxWord, 16'h0000);

    phase = "R6 first char";
    wcsr(16'h0040);
    push(4'd5, 8'h41, 0, 0);
    check(rxIrq === 1'b1, "R6 irq on first char", {15'b0, rxIrq}, 16'h0001);
    wcsr(16'h0040);
    push(4'd6, 8'h42, 0, 0);
    check(rxIrq === 1'b0, "R6 no irq when not empty", {15'b0, rxIrq}, 16'h0000);

    phase = "R7 alarm level";
    while (mq.size() > 0) pop();
    walarm(7'd5);
    push(4'd1, 8'h01, 0, 0);
    wcsr(16'h0040);
    for (int i = 2; i <= 4; i++) push(4'(i), 8'(i), 0, 0);
    check(csrRdData[7] === 1'b0, "R7 below alarm", {15'b0, csrRdData[7]}, 16'h0000);
    push(4'd5, 8'h05, 0, 0);
    check(csrRdData[7] === 1'b1, "R7 alarm reached", {15'b0, csrRdData[7]}, 16'h0001);
    wcsr(16'h0040);
    walarm(7'd64);
    while (mq.size() < DEPTH) push(4'(mq.size()), 8'(mq.size()), 0, 1);
    check(csrRdData[7] === 1'b1, "R7 alarm at full depth", {15'b0, csrRdData[7]}, 16'h0001);
    while (mq.size() > 0) pop();

    phase = "R8 set beats clear";
    wcsr(16'h0040);
    step(1, 4'd3, 8'h33, 0, 0, 0, 1, 16'h0040, 0, '0);
    check(csrRdData[7] === 1'b1, "R8 hardware set wins", {15'b0, csrRdData[7]}, 16'h0001);
    pop();
    wcsr(16'h0000);

    phase = "R9 maintenance force";
    wcsr(16'h0080);
    check(csrRdData[7] === 1'b0, "R8 flag write without maint", {15'b0, csrRdData[7]}, 16'h0000);
    wcsr(16'h02C0);
    check(rxIrq === 1'b1, "R9 forced irq", {15'b0, rxIrq}, 16'h0001);

    phase = "R10 enable gating";
    wcsr(16'h0280);
    check(rxIrq === 1'b0, "R10 irq masked", {15'b0, rxIrq}, 16'h0000);

    phase = "R11 master clear";
    wcsr(16'h0040);
    walarm(7'd9);
    for (int i = 0; i < 6; i++) push(4'(i), 8'(8'hF0 + i), 1, 1);
    step(1, 4'd4, 8'h44, 0, 0, 0, 1, 16'h0840, 0, '0);
    check(rxWord === 16'h0000, "R11 silo emptied", rxWord, 16'h0000);
    check(csrRdData === 16'h0000, "R11 control cleared", csrRdData, 16'h0000);
    push(4'd8, 8'h88, 0, 0);
    pop();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule